// File: doc/BRIEF.md
# Serial Loopback and Modem-Line Router

This block sits at the pin boundary of one serial channel, between the transmit serializer, the receive deserializer and the external TxD, RxD, CTS, DCD and DTR/request pins. Two mode bits steer the serial data. Local loopback feeds the transmitter's output back into the receiver and keeps driving TxD. Auto echo copies RxD straight onto TxD and discards the transmitter's output. Both bits may be set together. The receiver then takes the looped transmitter output and TxD carries the echoed RxD. This priority is fixed.

The block also produces the transmit and receive enables. With auto enable set, these follow the synchronized, active-low CTS and DCD inputs. The loop and echo modes override that gating. A level change on either modem input always raises a one-cycle change event. A combined DTR/request output either reflects a DTR control bit or acts as an active-low transmit DMA request. The request is raised when the transmit buffer becomes empty, or when the CRC has been sent in synchronous mode. It is released a fixed number of clocks after a bus strobe begins.

Configuration is loaded through a write strobe. Hardware reset and channel reset both clear it.

Top module: `serial_loop_router`

## Requirements
- R1: With loopback set and echo clear, `rx_ser_o` equals `tx_ser_i` and `txd_o` equals `tx_ser_i`, whatever `rxd_i` does.
- R2: With loopback set, `tx_en_o` and `rx_en_o` are both 1 even when auto enable is set and CTS/DCD are deasserted (high).
- R3: A level change on `cts_n_i` or `dcd_n_i` made before clock edge k pulses `cts_chg_o` or `dcd_chg_o` high for exactly the cycle between edges k+1 and k+2. This holds in every mode.
- R4: With echo set and loopback clear, `txd_o` equals `rxd_i` and `rx_ser_o` equals `rxd_i`. `tx_ser_i` has no effect on any pin, and `tx_en_o` is 1 regardless of CTS. `rx_en_o` still follows DCD when auto enable is set.
- R5: With both loopback and echo set, `rx_ser_o` equals `tx_ser_i` and `txd_o` equals `rxd_i`.
- R6: In normal mode with auto enable set, `tx_en_o` is 1 exactly when the CTS input, two flops after the pin, is low. `rx_en_o` is 1 exactly when DCD at the same point is low. With auto enable clear, both are 1.
- R7: With the request-function bit clear, `dtr_req_n_o` equals the inverse of the DTR bit.
- R8: With the request-function bit set, `dtr_req_n_o` goes low at the first edge after `tx_empty_i` rises. With the synchronous bit set, a rise of `crc_sent_i` does the same. With the synchronous bit clear, a rise of `crc_sent_i` has no effect.
- R9: While a request is pending, a strobe (`ds_n_i`, `rd_n_i` or `wr_n_i` going low) first seen at edge k drives `dtr_req_n_o` high at edge k+5. A strobe with no request pending has no effect.
- R10: Hardware reset (`rst_n` low) and channel reset (`chan_rst` high at an edge) clear every configuration bit and any pending request, which leaves `dtr_req_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset |
| cfg_we | input | 1 | Loads the six configuration bits |
| cfg_loop | input | 1 | Local loopback mode bit |
| cfg_echo | input | 1 | Auto echo mode bit |
| cfg_reqfn | input | 1 | Request-function select for the DTR pin |
| cfg_dtr | input | 1 | DTR control bit |
| cfg_auto | input | 1 | Auto enable: CTS/DCD gate the enables |
| cfg_sync | input | 1 | Synchronous mode: CRC-sent raises a request |
| tx_ser_i | input | 1 | Transmitter serial output |
| rxd_i | input | 1 | RxD pin |
| cts_n_i | input | 1 | CTS pin, active low, asynchronous |
| dcd_n_i | input | 1 | DCD pin, active low, asynchronous |
| tx_empty_i | input | 1 | Transmit buffer empty flag |
| crc_sent_i | input | 1 | End-of-message CRC sent flag |
| ds_n_i | input | 1 | Data strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| txd_o | output | 1 | TxD pin |
| rx_ser_o | output | 1 | Receiver serial input |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| cts_chg_o | output | 1 | CTS change event |
| dcd_chg_o | output | 1 | DCD change event |
| dtr_req_n_o | output | 1 | DTR / transmit request pin, active low |

## Verification
The change-event assertion assumes that CTS and DCD hold each level for at least two clocks. The stimulus therefore waits several cycles between modem-line transitions. The request assertions assume that `tx_empty_i` and `crc_sent_i` come from logic in the same clock domain, so the bench drives them only between edges. Bus strobes are held low for several cycles and released well before the next one. This keeps each release separate from a fresh request, except in the one case where the bench deliberately overlaps them.

// File: rtl/serial_loop_router.sv
module serial_loop_router #(
  parameter int REL_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic cfg_we,
  input  logic cfg_loop,
  input  logic cfg_echo,
  input  logic cfg_reqfn,
  input  logic cfg_dtr,
  input  logic cfg_auto,
  input  logic cfg_sync,
  input  logic tx_ser_i,
  input  logic rxd_i,
  input  logic cts_n_i,
  input  logic dcd_n_i,
  input  logic tx_empty_i,
  input  logic crc_sent_i,
  input  logic ds_n_i,
  input  logic rd_n_i,
  input  logic wr_n_i,
  output logic txd_o,
  output logic rx_ser_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic cts_chg_o,
  output logic dcd_chg_o,
  output logic dtr_req_n_o
);
  localparam int CW = $clog2(REL_CYCLES + 1);

  logic loop_q, echo_q, reqfn_q, dtr_q, auto_q, sync_q;
  logic [2:0] cts_p, dcd_p, stb_p;
  logic txe_q, crc_q, req_q;
  logic [CW-1:0] cnt_q;
  logic stb_any, stb_fall, set_req;

  assign stb_any  = ~(ds_n_i & rd_n_i & wr_n_i);
  assign stb_fall = stb_p[1] & ~stb_p[2];
  assign set_req  = (tx_empty_i & ~txe_q) | (sync_q & crc_sent_i & ~crc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_p <= 3'b111;
      dcd_p <= 3'b111;
      stb_p <= 3'b000;
      txe_q <= 1'b0;
      crc_q <= 1'b0;
    end else begin
      cts_p <= {cts_p[1:0], cts_n_i};
      dcd_p <= {dcd_p[1:0], dcd_n_i};
      stb_p <= {stb_p[1:0], stb_any};
      txe_q <= tx_empty_i;
      crc_q <= crc_sent_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {loop_q, echo_q, reqfn_q, dtr_q, auto_q, sync_q} <= '0;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else if (chan_rst) begin
      {loop_q, echo_q, reqfn_q, dtr_q, auto_q, sync_q} <= '0;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (cfg_we)
        {loop_q, echo_q, reqfn_q, dtr_q, auto_q, sync_q} <=
          {cfg_loop, cfg_echo, cfg_reqfn, cfg_dtr, cfg_auto, cfg_sync};
      if (!reqfn_q) begin
        req_q <= 1'b0;
        cnt_q <= '0;
      end else if (set_req) begin
        req_q <= 1'b1;
        cnt_q <= '0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) req_q <= 1'b0;
      end else if (stb_fall && req_q) begin
        cnt_q <= CW'(REL_CYCLES);
      end
    end
  end

  assign txd_o       = echo_q ? rxd_i : tx_ser_i;
  assign rx_ser_o    = loop_q ? tx_ser_i : rxd_i;
  assign tx_en_o     = ~auto_q | loop_q | echo_q | ~cts_p[1];
  assign rx_en_o     = ~auto_q | loop_q | ~dcd_p[1];
  assign cts_chg_o   = cts_p[1] ^ cts_p[2];
  assign dcd_chg_o   = dcd_p[1] ^ dcd_p[2];
  assign dtr_req_n_o = reqfn_q ? ~req_q : ~dtr_q;

  assert_chanrst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!loop_q && !echo_q && !reqfn_q && dtr_req_n_o));

  assert_loop_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q |-> (tx_en_o && rx_en_o));

  assert_echo_txd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_q && !loop_q) |-> (txd_o == rxd_i && rx_ser_o == rxd_i));

  assert_loop_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q |-> (rx_ser_o == tx_ser_i));

  assert_cts_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_chg_o && $stable(cts_n_i)) |=> !cts_chg_o);

  assert_req_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqfn_q && !chan_rst && tx_empty_i && !txe_q) |=> !dtr_req_n_o);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqfn_q && req_q && cnt_q == '0 && !stb_fall && !chan_rst) |=> req_q);

  assert_release_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_q) && $past(reqfn_q) && !$past(chan_rst)) |-> ($past(cnt_q) == CW'(1)));
endmodule

// File: tb/tb_serial_loop_router.sv
module tb_serial_loop_router;
  logic clk = 0, rst_n = 0, chan_rst = 0, cfg_we = 0;
  logic cfg_loop = 0, cfg_echo = 0, cfg_reqfn = 0, cfg_dtr = 0, cfg_auto = 0, cfg_sync = 0;
  logic tx_ser_i = 0, rxd_i = 1, cts_n_i = 1, dcd_n_i = 1;
  logic tx_empty_i = 0, crc_sent_i = 0, ds_n_i = 1, rd_n_i = 1, wr_n_i = 1;
  logic txd_o, rx_ser_o, tx_en_o, rx_en_o, cts_chg_o, dcd_chg_o, dtr_req_n_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_loop_router dut (.*);

  // reference model state
  int m_loop, m_echo, m_reqfn, m_dtr, m_auto, m_sync;
  int ca = 1, cb = 1, cc = 1, da = 1, db = 1, dc = 1, sa = 0, sb = 0, sc = 0;
  int txe_p = 0, crc_p = 0, req = 0, cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loop = 0; m_echo = 0; m_reqfn = 0; m_dtr = 0; m_auto = 0; m_sync = 0;
      ca = 1; cb = 1; cc = 1; da = 1; db = 1; dc = 1; sa = 0; sb = 0; sc = 0;
      txe_p = 0; crc_p = 0; req = 0; cnt = 0;
    end else begin
      int set, fall, old_reqfn, old_sync;
      old_reqfn = m_reqfn; old_sync = m_sync;
      set = (tx_empty_i && !txe_p) || (old_sync && crc_sent_i && !crc_p);
      fall = sb && !sc;
      if (chan_rst) begin
        m_loop = 0; m_echo = 0; m_reqfn = 0; m_dtr = 0; m_auto = 0; m_sync = 0;
        req = 0; cnt = 0;
      end else begin
        if (cfg_we) begin
          m_loop = cfg_loop; m_echo = cfg_echo; m_reqfn = cfg_reqfn;
          m_dtr = cfg_dtr; m_auto = cfg_auto; m_sync = cfg_sync;
        end
        if (!old_reqfn) begin req = 0; cnt = 0; end
        else if (set) begin req = 1; cnt = 0; end
        else if (cnt != 0) begin
          if (cnt == 1) req = 0;
          cnt = cnt - 1;
        end else if (fall && req) cnt = 3;
      end
      cc = cb; cb = ca; ca = cts_n_i;
      dc = db; db = da; da = dcd_n_i;
      sc = sb; sb = sa; sa = !(ds_n_i && rd_n_i && wr_n_i);
      txe_p = tx_empty_i; crc_p = crc_sent_i;
    end
  end

  task automatic chk(string req_tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req_tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e_txd, e_rx, e_ten, e_ren, e_pin;
    string t_txd, t_rx, t_en;
    e_txd = m_echo ? rxd_i : tx_ser_i;
    e_rx  = m_loop ? tx_ser_i : rxd_i;
    e_ten = !m_auto || m_loop || m_echo || !cb;
    e_ren = !m_auto || m_loop || !db;
    e_pin = m_reqfn ? !req : !m_dtr;
    t_txd = m_echo ? (m_loop ? "R5" : "R4") : (m_loop ? "R1" : "R6");
    t_rx  = m_loop ? (m_echo ? "R5" : "R1") : "R4";
    t_en  = m_loop ? "R2" : (m_echo ? "R4" : "R6");
    chk(t_txd, "txd", txd_o, e_txd);
    chk(t_rx, "rx_ser", rx_ser_o, e_rx);
    chk(t_en, "tx_en", tx_en_o, e_ten);
    chk(t_en, "rx_en", rx_en_o, e_ren);
    chk("R3", "cts_chg", cts_chg_o, logic'(cb != cc));
    chk("R3", "dcd_chg", dcd_chg_o, logic'(db != dc));
    chk(m_reqfn ? "R9" : "R7", "dtr_req_n", dtr_req_n_o, e_pin);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      if (rst_n) compare();
    end
  endtask

  task automatic cfg(bit lp, bit ec, bit rf, bit dt, bit au, bit sy);
    cfg_we = 1; cfg_loop = lp; cfg_echo = ec; cfg_reqfn = rf;
    cfg_dtr = dt; cfg_auto = au; cfg_sync = sy;
    tick();
    cfg_we = 0;
  endtask

  task automatic data_run(int n);
    for (int i = 0; i < n; i++) begin
      tx_ser_i = i[0] ^ i[2];
      rxd_i = i[1];
      tick();
    end
  endtask

  task automatic modem(bit c, bit d);
    cts_n_i = c; dcd_n_i = d;
    tick(4);
  endtask

  task automatic strobe(int which);
    case (which)
      0: ds_n_i = 0;
      1: rd_n_i = 0;
      default: wr_n_i = 0;
    endcase
    tick(3);
    ds_n_i = 1; rd_n_i = 1; wr_n_i = 1;
  endtask

  initial begin
    // R10: hardware reset state
    tick(2);
    #1;
    checks++; if (dtr_req_n_o !== 1'b1) begin fails++; $display("FAIL R10 reset pin: actual %b expected 1", dtr_req_n_o); end
    checks++; if (cts_chg_o !== 1'b0) begin fails++; $display("FAIL R10 reset cts_chg: actual %b expected 0", cts_chg_o); end
    rst_n = 1;
    tick(2);

    // R6: normal mode, auto enable off then on
    data_run(8);
    cfg(0, 0, 0, 0, 1, 0);
    modem(0, 1); modem(0, 0); modem(1, 0); modem(1, 1);
    data_run(8);

    // R1 / R2: local loopback ignores CTS/DCD, R3 events still fire
    cfg(1, 0, 0, 0, 1, 0);
    data_run(12);
    modem(0, 1); modem(1, 0); modem(1, 1);

    // R4: echo
    cfg(0, 1, 0, 0, 1, 0);
    data_run(12);
    modem(1, 0); modem(1, 1); modem(0, 1);

    // R5: both modes
    cfg(1, 1, 0, 0, 1, 0);
    data_run(12);
    modem(1, 1);

    // R7: DTR mirror
    cfg(0, 0, 0, 1, 0, 0);
    tick(2);
    cfg(0, 0, 0, 0, 0, 0);
    tick(2);

    // R8 / R9: request mode, buffer empty then strobes
    cfg(0, 0, 1, 0, 0, 0);
    strobe(0); tick(6);               // R9: no request pending, no effect
    tx_empty_i = 1; tick(2);
    strobe(1); tick(8);
    tx_empty_i = 0; tick(2);
    tx_empty_i = 1; tick(2);
    strobe(2); tick(8);
    // R8: crc ignored without sync
    tx_empty_i = 0; crc_sent_i = 1; tick(4);
    crc_sent_i = 0; tick(2);
    cfg(0, 0, 1, 0, 0, 1);
    crc_sent_i = 1; tick(2);
    strobe(0); tick(2);
    // new request during release count
    tx_empty_i = 1; tick(8);
    crc_sent_i = 0; strobe(1); tick(8);

    // R10: channel reset clears a pending request and modes
    tx_empty_i = 0; tick();
    cfg(1, 1, 1, 1, 1, 1);
    tx_empty_i = 1; tick(2);
    chan_rst = 1; tick(); chan_rst = 0;
    tick(3);
    data_run(6);

    // R10: hardware reset mid-run
    cfg(1, 0, 1, 1, 1, 0);
    tx_empty_i = 0; tick(); tx_empty_i = 1; tick(2);
    rst_n = 0; #1;
    checks++; if (dtr_req_n_o !== 1'b1) begin fails++; $display("FAIL R10 async reset pin: actual %b expected 1", dtr_req_n_o); end
    tick(2);
    rst_n = 1; tx_empty_i = 0;
    tick(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule